// File: doc/BRIEF.md
# Authority Mask Register Unit

This unit holds two 64-bit special-purpose registers: the authority mask, which grants read and write permission to each of 32 storage-protection key classes, and a companion user-modifiable mask that decides which authority mask bits an unprivileged program may change. Requests arrive one per cycle. Each carries a register number, a read/write flag, write data and a privilege tag. The unit returns read data, a hit flag for a mapped number, and an illegal-access flag.

The authority mask can be reached through two register numbers. The user-visible alias (13) accepts accesses in either privilege state. When an unprivileged write comes through it, the write data is first ANDed with the user-modifiable mask, so only the permitted bits change. The privileged alias (29) and the user-modifiable mask (157) reject unprivileged accesses. The current authority mask is also driven out continuously, for use by the page key checker.

Top module: `amr_spr_unit`

## Requirements
- R1: After reset both registers hold zero. The authority mask output reads zero, and so does a privileged read of number 157.
- R2: A read at number 13 returns the full authority mask in both user state (req_user=1) and privileged state (req_user=0).
- R3: A user-state write at number 13 stores the write data ANDed with the user-modifiable mask.
- R4: A privileged write at number 13 or number 29 stores the full write data, with no masking.
- R5: A privileged read at number 29 returns the full authority mask.
- R6: In privileged state, number 157 reads and writes the user-modifiable mask.
- R7: A user-state access to number 29 or 157 raises rsp_illegal, returns zero read data and changes neither register.
- R8: A write takes effect on the clock edge that ends its cycle. During the write cycle, amr_value and reads still show the old value.
- R9: A number other than 13, 29 or 157, or a cycle with req_valid low, gives rsp_hit=0, rsp_illegal=0 and zero read data, and changes no state.
- R10: amr_value always presents the stored authority mask. Read data is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = user state, 0 = privileged |
| req_num | input | 10 | Register number |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, valid in the request cycle |
| rsp_hit | output | 1 | Request targets a mapped number |
| rsp_illegal | output | 1 | Privilege violation |
| amr_value | output | 64 | Current authority mask for the key checker |

## Verification
A corrupted authority mask appears on amr_value in the cycle after the faulty write, so every write vector is checked one edge later. A wrong user-modifiable mask is visible only through its effect on later user writes, or through a privileged read of number 157. For that reason the stimulus reads the mask back after writing it and after each rejected access. A decode error that lets a user-state access through to number 29 or 157 shows up immediately, as a missing illegal flag or a change to amr_value.

// File: rtl/amr_pkg.sv
package amr_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_AMR  = 2'd1,
        TGT_MASK = 2'd2
    } tgt_e;

    typedef struct packed {
        logic hit;
        logic illegal;
        tgt_e tgt;
        logic masked;
    } dec_t;

endpackage

// File: rtl/amr_decode.sv
module amr_decode
    import amr_pkg::*;
#(
    parameter int NUM_W    = 10,
    parameter int NUM_USER = 13,
    parameter int NUM_PRIV = 29,
    parameter int NUM_MASK = 157
) (
    input  logic [NUM_W-1:0] num,
    input  logic             user,
    output dec_t             dec
);

    localparam logic [NUM_W-1:0] N_USER = NUM_W'(NUM_USER);
    localparam logic [NUM_W-1:0] N_PRIV = NUM_W'(NUM_PRIV);
    localparam logic [NUM_W-1:0] N_MASK = NUM_W'(NUM_MASK);

    always_comb begin
        dec = '{hit: 1'b0, illegal: 1'b0, tgt: TGT_NONE, masked: 1'b0};
        if (num == N_USER) begin
            dec.hit    = 1'b1;
            dec.tgt    = TGT_AMR;
            dec.masked = user;
        end else if (num == N_PRIV || num == N_MASK) begin
            dec.hit = 1'b1;
            if (user) begin
                dec.illegal = 1'b1;
            end else begin
                dec.tgt = (num == N_PRIV) ? TGT_AMR : TGT_MASK;
            end
        end
    end

endmodule

// File: rtl/amr_regs.sv
module amr_regs #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_amr,
    input  logic              wr_mask,
    input  logic              masked,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] amr_q,
    output logic [DATA_W-1:0] mask_q
);

    typedef struct packed {
        logic [DATA_W-1:0] amr;
        logic [DATA_W-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_amr) begin
            st_d.amr = masked ? (wdata & st_q.mask) : wdata;
        end
        if (wr_mask) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign amr_q  = st_q.amr;
    assign mask_q = st_q.mask;

    assert_priv_write_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_amr && !masked) |=> amr_q == $past(wdata));

    assert_user_write_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_amr && masked) |=> amr_q == ($past(wdata) & $past(mask_q)));

    assert_amr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_amr |=> $stable(amr_q));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (amr_q == '0 && mask_q == '0));

endmodule

// File: rtl/amr_spr_unit.sv
module amr_spr_unit
    import amr_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_W    = 10,
    parameter int NUM_USER = 13,
    parameter int NUM_PRIV = 29,
    parameter int NUM_MASK = 157
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [NUM_W-1:0]  req_num,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_hit,
    output logic              rsp_illegal,
    output logic [DATA_W-1:0] amr_value
);

    dec_t              dec;
    logic              wr_amr, wr_mask, rd_ok;
    logic [DATA_W-1:0] amr_q, mask_q;

    amr_decode #(
        .NUM_W   (NUM_W),
        .NUM_USER(NUM_USER),
        .NUM_PRIV(NUM_PRIV),
        .NUM_MASK(NUM_MASK)
    ) u_decode (
        .num (req_num),
        .user(req_user),
        .dec (dec)
    );

    always_comb begin
        wr_amr      = req_valid && req_write && dec.tgt == TGT_AMR;
        wr_mask     = req_valid && req_write && dec.tgt == TGT_MASK;
        rd_ok       = req_valid && !req_write && dec.tgt != TGT_NONE;
        rsp_hit     = req_valid && dec.hit;
        rsp_illegal = req_valid && dec.illegal;
        rsp_rdata   = '0;
        if (rd_ok) begin
            rsp_rdata = (dec.tgt == TGT_MASK) ? mask_q : amr_q;
        end
    end

    amr_regs #(
        .DATA_W(DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_amr (wr_amr),
        .wr_mask(wr_mask),
        .masked (dec.masked),
        .wdata  (req_wdata),
        .amr_q  (amr_q),
        .mask_q (mask_q)
    );

    assign amr_value = amr_q;

    assert_illegal_no_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |=> ($stable(amr_value) && $stable(mask_q)));

    assert_illegal_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> (rsp_rdata == '0 && rsp_hit));

    assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_rdata == '0 && !rsp_illegal));

    assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_amr, wr_mask, rsp_illegal}));

endmodule

// File: tb/amr_spr_unit_tb.sv
module amr_spr_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    typedef struct packed {
        logic        valid;
        logic        write;
        logic        user;
        logic [9:0]  num;
        logic [63:0] wdata;
        logic [63:0] exp_rdata;
        logic        exp_hit;
        logic        exp_ill;
        logic [63:0] exp_amr;
    } vec_t;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MSK  = 64'h00FF_00FF_00FF_00FF;
    localparam logic [63:0] WD   = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] WDM  = 64'h0034_0078_00BC_00F0;
    localparam logic [63:0] A5   = 64'hA5A5_A5A5_A5A5_A5A5;
    localparam logic [63:0] F0   = 64'h0F0F_0F0F_0F0F_0F0F;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 10'd13,  64'd0, 64'd0, 1'b1, 1'b0, 64'd0},
        '{1'b1, 1'b1, 1'b1, 10'd13,  ONES,  64'd0, 1'b1, 1'b0, 64'd0},
        '{1'b1, 1'b1, 1'b0, 10'd157, MSK,   64'd0, 1'b1, 1'b0, 64'd0},
        '{1'b1, 1'b0, 1'b0, 10'd157, 64'd0, MSK,   1'b1, 1'b0, 64'd0},
        '{1'b1, 1'b1, 1'b1, 10'd13,  WD,    64'd0, 1'b1, 1'b0, WDM},
        '{1'b1, 1'b0, 1'b1, 10'd13,  64'd0, WDM,   1'b1, 1'b0, WDM},
        '{1'b1, 1'b1, 1'b0, 10'd29,  A5,    64'd0, 1'b1, 1'b0, A5},
        '{1'b1, 1'b0, 1'b0, 10'd13,  64'd0, A5,    1'b1, 1'b0, A5},
        '{1'b1, 1'b1, 1'b0, 10'd13,  F0,    64'd0, 1'b1, 1'b0, F0},
        '{1'b1, 1'b0, 1'b0, 10'd29,  64'd0, F0,    1'b1, 1'b0, F0},
        '{1'b1, 1'b0, 1'b1, 10'd29,  64'd0, 64'd0, 1'b1, 1'b1, F0},
        '{1'b1, 1'b1, 1'b1, 10'd29,  ONES,  64'd0, 1'b1, 1'b1, F0},
        '{1'b1, 1'b1, 1'b1, 10'd157, ONES,  64'd0, 1'b1, 1'b1, F0},
        '{1'b1, 1'b0, 1'b0, 10'd157, 64'd0, MSK,   1'b1, 1'b0, F0},
        '{1'b1, 1'b0, 1'b1, 10'd157, 64'd0, 64'd0, 1'b1, 1'b1, F0},
        '{1'b1, 1'b1, 1'b0, 10'd32,  ONES,  64'd0, 1'b0, 1'b0, F0},
        '{1'b1, 1'b1, 1'b1, 10'd13,  ONES,  64'd0, 1'b1, 1'b0, MSK},
        '{1'b0, 1'b1, 1'b0, 10'd29,  ONES,  64'd0, 1'b0, 1'b0, MSK}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [9:0]  req_num = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rsp_rdata, amr_value;
    logic        rsp_hit, rsp_illegal;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amr_spr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_user(req_user), .req_num(req_num), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit), .rsp_illegal(rsp_illegal),
        .amr_value(amr_value)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic u,
                         input logic [9:0] n, input logic [63:0] d);
        @(negedge clk);
        req_valid = v; req_write = w; req_user = u; req_num = n; req_wdata = d;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset amr_value", amr_value, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2..R7, R9, R10
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].valid, VECS[i].write, VECS[i].user, VECS[i].num, VECS[i].wdata);
            chk($sformatf("R2/R5/R6/R10 rdata vec %0d", i), rsp_rdata, VECS[i].exp_rdata);
            chk($sformatf("R9 hit vec %0d", i), 64'(rsp_hit), 64'(VECS[i].exp_hit));
            chk($sformatf("R7 illegal vec %0d", i), 64'(rsp_illegal), 64'(VECS[i].exp_ill));
            @(posedge clk);
            #1;
            chk($sformatf("R3/R4 amr after vec %0d", i), amr_value, VECS[i].exp_amr);
        end

        // R8: write cycle still shows old value, new value after edge
        drive(1'b1, 1'b1, 1'b0, 10'd29, A5);
        chk("R8 amr during write", amr_value, MSK);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_user = 1'b0; req_num = 10'd13;
        #1;
        chk("R8 read after write", rsp_rdata, A5);

        // R1: reset in mid-run clears both registers
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1 async reset amr", amr_value, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 10'd157, 64'd0);
        chk("R1 mask zero after reset", rsp_rdata, 64'd0);
        drive(1'b1, 1'b1, 1'b1, 10'd13, ONES);
        @(posedge clk);
        #1;
        chk("R3 zero mask blocks user write", amr_value, 64'd0);

        @(negedge clk);
        req_valid = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule